// File: doc/BRIEF.md
# Programmable-Length Reed-Solomon Encoder

This block adds forward error protection to a byte stream. It is a systematic Reed-Solomon encoder over GF(2^8). Each block of message bytes comes out of the encoder unchanged and is followed by 16 check bytes, so a decoder can correct up to 8 corrupted bytes per codeword. The total codeword length N can be set for each block, which gives shortened codes for short packets. Every block is framed by a start flag on its first byte. The block keeps a fixed two-cycle latency and accepts one byte per clock while message bytes are streaming.

The codeword length and a bypass control are sampled together with the first byte of a block. Software can therefore change either one while a block is in progress, and the change applies to the next block. In bypass the block passes N bytes through unchanged and adds nothing. While check bytes are being emitted, `in_ready` is held low so the upstream source waits.

Top module: `rs_stream_encoder`

## Requirements
- R1: In coded mode, the message bytes come out unchanged and in order. They are followed by 16 check bytes that form the remainder of m(x)·x^16 divided by g(x). The check bytes are emitted highest degree first. The first message byte is the highest-degree coefficient of m(x). The field is built on x^8+x^4+x^3+x^2+1 (0x11D), and g(x) has the roots alpha^0 through alpha^15 with alpha = 0x02.
- R2: `cfg_len` (8 bits, unsigned) is the codeword length N. In coded mode a block takes N−16 message bytes and produces N output bytes.
- R3: A `cfg_len` value below 20 is treated as N = 20.
- R4: `cfg_len` and `cfg_bypass` are sampled only on the byte that carries `in_sop`. Changing them during a block has no effect on that block.
- R5: A byte presented in cycle c appears at the output in cycle c+2. A whole codeword leaves the block on consecutive cycles.
- R6: In coded mode, `in_ready` is low for exactly 16 cycles, starting in the cycle after the last message byte is accepted. At all other times it is high.
- R7: In bypass, a block is N bytes passed through unchanged. No check bytes are added and `in_ready` stays high.
- R8: `out_sop` marks the first output byte of a codeword. `out_eob` marks the last output byte of a codeword. `out_parity` is high on check bytes only.
- R9: A byte presented while idle without `in_sop` is discarded and produces no output.
- R10: The check bytes of a block do not depend on any earlier block, including blocks sent back to back.
- R11: After reset, `in_ready` is high and `out_valid`, `out_sop`, `out_eob` and `out_parity` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 8 | Codeword length N, sampled at block start |
| cfg_bypass | input | 1 | Pass the block through without coding, sampled at block start |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a block |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Encoder can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of an output codeword |
| out_eob | output | 1 | Last byte of an output codeword |
| out_parity | output | 1 | Output byte is a check byte |

## Verification
If the check register holds a wrong value, or is not cleared between blocks, the next codeword's check bytes differ from a long-division reference. This shows up within 16 cycles of the last message byte. A miscounted length moves `out_eob` and changes the number of cycles that `in_ready` stays low, which is visible at the end of the block. The reference divides a full polynomial with log/antilog arithmetic, so it does not share the encoder's shift structure.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  localparam int unsigned SYM_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} rs_state_e;

  // Carry-less multiply of two field elements, reduced by the field polynomial
  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b,
                                               input logic [SYM_W-1:0] poly_low);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ poly_low) : (x << 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
  parameter int unsigned NPAR       = 16,
  parameter logic [8:0]  FIELD_POLY = 9'h11D,
  parameter int unsigned FIRST_ROOT = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           feed,
  input  logic                           shift,
  input  logic [rs_enc_pkg::SYM_W-1:0]   din,
  output logic [rs_enc_pkg::SYM_W-1:0]   top
);
  localparam int unsigned SW = rs_enc_pkg::SYM_W;
  localparam logic [SW-1:0] POLY8 = FIELD_POLY[SW-1:0];

  // Product of (x + alpha^i) over NPAR consecutive roots
  function automatic logic [NPAR:0][SW-1:0] gen_poly();
    logic [NPAR:0][SW-1:0] g;
    logic [SW-1:0] root;
    g    = '0;
    g[0] = SW'(1);
    root = SW'(1);
    for (int k = 0; k < int'(FIRST_ROOT); k++) root = rs_enc_pkg::gf_mul(root, SW'(2), POLY8);
    for (int i = 0; i < int'(NPAR); i++) begin
      for (int j = int'(NPAR); j >= 1; j--) g[j] = g[j-1] ^ rs_enc_pkg::gf_mul(g[j], root, POLY8);
      g[0] = rs_enc_pkg::gf_mul(g[0], root, POLY8);
      root = rs_enc_pkg::gf_mul(root, SW'(2), POLY8);
    end
    return g;
  endfunction

  localparam logic [NPAR:0][SW-1:0] GEN = gen_poly();

  logic [NPAR-1:0][SW-1:0] par;
  logic [NPAR-1:0][SW-1:0] prod;
  logic [SW-1:0]           fb;

  assign fb  = din ^ par[NPAR-1];
  assign top = par[NPAR-1];

  for (genvar gi = 0; gi < int'(NPAR); gi++) begin : g_tap
    assign prod[gi] = rs_enc_pkg::gf_mul(fb, GEN[gi], POLY8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par <= '0;
    end else if (feed) begin
      par[0] <= prod[0];
      for (int i = 1; i < int'(NPAR); i++) par[i] <= par[i-1] ^ prod[i];
    end else if (shift) begin
      par <= {par[NPAR-2:0], {SW{1'b0}}};
    end
  end

  // R1: division and emission never overlap
  assert_no_feed_during_shift_R1: assert property (@(posedge clk) disable iff (rst)
    !(feed && shift));

endmodule

// File: rtl/rs_frame_ctrl.sv
module rs_frame_ctrl #(
  parameter int unsigned NPAR    = 16,
  parameter int unsigned MIN_LEN = 20,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_bypass,
  output logic             in_ready,
  output logic             take,
  output logic             take_first,
  output logic             take_last,
  output logic             byp,
  output logic             feed,
  output logic             shift,
  output logic             par_last
);
  import rs_enc_pkg::*;

  localparam int unsigned PW = (NPAR > 1) ? $clog2(NPAR) : 1;

  rs_state_e        state;
  logic [LEN_W-1:0] cnt;
  logic [PW-1:0]    pcnt;
  logic             byp_q;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] blk_len;

  always_comb begin
    eff_len    = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_len;
    blk_len    = cfg_bypass ? eff_len : (eff_len - LEN_W'(NPAR));
    in_ready   = (state != ST_PAR);
    take       = in_valid && ((state == ST_MSG) || ((state == ST_IDLE) && in_sop));
    take_first = take && (state == ST_IDLE);
    take_last  = take && (state == ST_MSG) && (cnt == LEN_W'(1));
    byp        = (state == ST_IDLE) ? cfg_bypass : byp_q;
    feed       = take && !byp;
    shift      = (state == ST_PAR);
    par_last   = (state == ST_PAR) && (pcnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pcnt  <= '0;
      byp_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          cnt   <= blk_len - LEN_W'(1);
          byp_q <= cfg_bypass;
          state <= ST_MSG;
        end
        ST_MSG: if (take) begin
          cnt <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) begin
            state <= byp_q ? ST_IDLE : ST_PAR;
            pcnt  <= PW'(NPAR - 1);
          end
        end
        ST_PAR: begin
          pcnt <= pcnt - PW'(1);
          if (pcnt == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the source is held off right after the last coded message byte
  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (take_last && !byp) |=> !in_ready);

  // R3: a started block never counts fewer message bytes than the floor length allows
  assert_len_floor_R3: assert property (@(posedge clk) disable iff (rst)
    take_first |=> (cnt >= LEN_W'(MIN_LEN - NPAR - 1)));

endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder #(
  parameter int unsigned PAR_SYMS   = 16,
  parameter int unsigned MIN_LEN    = 20,
  parameter int unsigned LEN_W      = 8,
  parameter logic [8:0]  FIELD_POLY = 9'h11D,
  parameter int unsigned FIRST_ROOT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_bypass,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eob,
  output logic             out_parity
);
  localparam int unsigned SW = rs_enc_pkg::SYM_W;

  logic          take, take_first, take_last, byp, feed, shift, par_last;
  logic [SW-1:0] par_top;

  logic          s1_v, s1_sop, s1_eob, s1_par;
  logic [SW-1:0] s1_d;

  rs_frame_ctrl #(.NPAR(PAR_SYMS), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .cfg_len(cfg_len), .cfg_bypass(cfg_bypass), .in_ready(in_ready),
    .take(take), .take_first(take_first), .take_last(take_last), .byp(byp),
    .feed(feed), .shift(shift), .par_last(par_last)
  );

  rs_lfsr #(.NPAR(PAR_SYMS), .FIELD_POLY(FIELD_POLY), .FIRST_ROOT(FIRST_ROOT)) lfsr_i (
    .clk(clk), .rst(rst), .feed(feed), .shift(shift), .din(in_data), .top(par_top)
  );

  // Stage 1: select message or check byte
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_d <= '0; s1_sop <= 1'b0; s1_eob <= 1'b0; s1_par <= 1'b0;
    end else begin
      s1_v   <= take || shift;
      s1_d   <= shift ? par_top : in_data;
      s1_sop <= take_first;
      s1_eob <= (take_last && byp) || par_last;
      s1_par <= shift;
    end
  end

  // Stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_data <= '0; out_sop <= 1'b0; out_eob <= 1'b0; out_parity <= 1'b0;
    end else begin
      out_valid  <= s1_v;
      out_data   <= s1_d;
      out_sop    <= s1_sop;
      out_eob    <= s1_eob;
      out_parity <= s1_par;
    end
  end

  assert_eob_has_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_eob |-> out_valid);

  assert_sop_is_message_R8: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> (out_valid && !out_parity));

  // R5: check bytes leave in one unbroken run
  assert_parity_run_R5: assert property (@(posedge clk) disable iff (rst)
    (out_parity && !out_eob) |=> (out_valid && out_parity));

  // R6: the source is released by the time the codeword ends
  assert_ready_at_eob_R6: assert property (@(posedge clk) disable iff (rst)
    out_eob |-> in_ready);

endmodule

// File: tb/rs_stream_encoder_tb_top.sv
module rs_stream_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_len = 8'd255;
  logic       cfg_bypass = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_sop, out_eob, out_parity;
  logic [7:0] out_data;

  rs_stream_encoder dut_i (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eob(out_eob), .out_parity(out_parity)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Capture
  int   rx_n = 0;
  int   rx_d [0:511];
  bit   rx_s [0:511], rx_e [0:511], rx_p [0:511];
  int   rx_c [0:511];
  always @(negedge clk) if (out_valid && rx_n < 512) begin
    rx_d[rx_n] = out_data; rx_s[rx_n] = out_sop; rx_e[rx_n] = out_eob;
    rx_p[rx_n] = out_parity; rx_c[rx_n] = cyc; rx_n = rx_n + 1;
  end

  // Field tables and generator
  int gexp [0:254];
  int glog [0:255];
  int gen  [0:NP];

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 255];
  endfunction

  task automatic build_field();
    int x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x; glog[x] = i;
      x = x << 1;
      if (x & 256) x = x ^ 'h11D;
    end
    for (int j = 0; j <= NP; j++) gen[j] = 0;
    gen[0] = 1;
    for (int i = 0; i < NP; i++) begin
      for (int j = NP; j >= 1; j--) gen[j] = gen[j-1] ^ fmul(gen[j], gexp[i]);
      gen[0] = fmul(gen[0], gexp[i]);
    end
  endtask

  int tx [0:511];
  int exp_par [0:NP-1];

  // Long division of m(x)*x^16 by g(x), index 0 = highest degree
  task automatic ref_parity(int len);
    int c [0:511];
    for (int k = 0; k < len + NP; k++) c[k] = (k < len) ? tx[k] : 0;
    for (int k = 0; k < len; k++) begin
      int coef = c[k];
      if (coef != 0)
        for (int j = 0; j <= NP; j++) c[k+j] = c[k+j] ^ fmul(coef, gen[NP-j]);
    end
    for (int j = 0; j < NP; j++) exp_par[j] = c[len+j];
  endtask

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Drive one block; returns lows of in_ready after it and the drive cycle of byte 0
  task automatic send_block(int ncfg, bit byp, int nsend, int kind, int chg_at,
                            int chg_len, bit chg_byp, output int lows, output int c0);
    for (int i = 0; i < nsend; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      tx[i] = (kind == 0) ? 0 : ((i * kind + 7 * i * i + kind) & 255);
      in_valid = 1'b1; in_sop = (i == 0); in_data = tx[i][7:0];
      if (i == 0) begin cfg_len = ncfg[7:0]; cfg_bypass = byp; c0 = cyc; end
      if (i == chg_at) begin cfg_len = chg_len[7:0]; cfg_bypass = chg_byp; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    lows = 0;
    while (!in_ready && lows < 100) begin lows++; @(negedge clk); end
    repeat (8) @(negedge clk);
  endtask

  // Compare one captured codeword
  task automatic verify_block(string tag, int ncfg, bit byp, int lows, int c0);
    int neff = (ncfg < 20) ? 20 : ncfg;
    int mlen = byp ? neff : neff - NP;
    int bad = 0, badf = 0;
    chk(rx_n == neff, tag, "codeword byte count (R2)", rx_n, neff);
    if (!byp) ref_parity(mlen);
    for (int i = 0; i < neff && i < rx_n; i++) begin
      int ev = (i < mlen) ? tx[i] : exp_par[i - mlen];
      if (rx_d[i] != ev) begin
        if (bad == 0) $display("FAIL %s byte %0d (R1): actual %0d expected %0d", tag, i, rx_d[i], ev);
        bad++;
      end
      if (rx_s[i] != (i == 0) || rx_e[i] != (i == neff - 1) || rx_p[i] != (i >= mlen)) badf++;
    end
    checks++; if (bad != 0) errors++;
    chk(badf == 0, tag, "sop/eob/parity flags wrong count (R8)", badf, 0);
    chk(lows == (byp ? 0 : NP), tag, "in_ready low cycles (R6 R7)", lows, byp ? 0 : NP);
    chk(rx_n > 0 && rx_c[0] - c0 == 2, tag, "first byte latency (R5)", rx_n > 0 ? rx_c[0] - c0 : -1, 2);
    chk(rx_n > 0 && rx_c[rx_n-1] - rx_c[0] == rx_n - 1, tag, "codeword contiguous (R5)",
        rx_n > 0 ? rx_c[rx_n-1] - rx_c[0] : -1, rx_n - 1);
  endtask

  task automatic run_block(string tag, int ncfg, bit byp, int kind);
    int lows, c0, neff, mlen;
    neff = (ncfg < 20) ? 20 : ncfg;
    mlen = byp ? neff : neff - NP;
    rx_n = 0;
    send_block(ncfg, byp, mlen, kind, -1, 0, 1'b0, lows, c0);
    verify_block(tag, ncfg, byp, lows, c0);
  endtask

  task automatic test_reset();
    chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
    chk({out_valid, out_sop, out_eob, out_parity} == 4'b0, "R11", "output flags after reset",
        {out_valid, out_sop, out_eob, out_parity}, 0);
  endtask

  task automatic test_full_length();   run_block("R1 N=255", 255, 1'b0, 3); endtask
  task automatic test_zero_message();  run_block("R1 zero msg", 40, 1'b0, 0); endtask
  task automatic test_shortest();      run_block("R2 N=20", 20, 1'b0, 11); endtask
  task automatic test_clamp();         run_block("R3 N=5", 5, 1'b0, 29); endtask
  task automatic test_bypass();        run_block("R7 bypass N=30", 30, 1'b1, 5); endtask

  task automatic test_midblock_change();
    int lows, c0;
    rx_n = 0;
    send_block(24, 1'b0, 8, 17, 3, 100, 1'b1, lows, c0);
    verify_block("R4 mid-block cfg change", 24, 1'b0, lows, c0);
  endtask

  task automatic test_idle_discard();
    rx_n = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(i + 9);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(rx_n == 0, "R9", "bytes output from sop-less idle input", rx_n, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after sop-less input", in_ready, 1);
  endtask

  task automatic test_back_to_back();
    int lows, c0;
    rx_n = 0;
    send_block(60, 1'b0, 44, 23, -1, 0, 1'b0, lows, c0);
    rx_n = 0;
    send_block(36, 1'b0, 20, 41, -1, 0, 1'b0, lows, c0);
    verify_block("R10 second block", 36, 1'b0, lows, c0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    build_field();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_full_length();
    test_zero_message();
    test_shortest();
    test_clamp();
    test_bypass();
    test_midblock_change();
    test_idle_discard();
    test_back_to_back();
    run_block("R1 after bypass", 50, 1'b0, 77);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule